// File: doc/BRIEF.md
# Target-Time Periodic Pulse Generator

This block watches a free-running time value, given as whole seconds plus nanoseconds, and compares it against a programmed target time on each of two independent event channels. When a channel's target is reached, the channel produces a pulse. The pulse width comes from a 4-bit code that selects a fixed ladder of durations, and the pulse polarity is programmable. The channel then moves its target forward by its reload period, so the pulses repeat at that period without any help from software.

Ten general-purpose pins can each carry either channel. A 3-bit selector field per pin does the routing. A pin drives only when its enable, direction and buffer bits are all set.

The time counter itself is an input. Configuration arrives as single 16-bit register writes on a plain write strobe. Every register is write-only, and the block reports nothing back.

Top module: `target_pulse_gen`

## Requirements
- R1: While and after reset, until software writes configuration, every pin has its output-enable low and its output low, and neither channel produces a pulse.
- R2: A channel produces no pulse while the time input is earlier than its target. This holds down to a one-nanosecond difference.
- R3: A pulse lasts ceil(W / NS_PER_CYCLE) clock cycles, with a minimum of 1. W is selected by the width code: 0=100 ns, 1=500 ns, 2=1 us, 3=5 us, 4=10 us, 5=50 us, 6=100 us, 7=500 us, 8=1 ms, 9=5 ms, 10=10 ms, 11=50 ms, 12=100 ms, 13=200 ms, and codes 14 and 15 mean 100 ns. A target hit that occurs while a pulse is still running does not lengthen that pulse.
- R4: The configuration register is at address 0x00. Channel A takes its polarity from bit 1 and its width code from bits 7:4. Channel B takes its polarity from bit 3 and its width code from bits 11:8. A polarity of 1 gives an idle-low, high-going pulse. A polarity of 0 gives an idle-high, low-going pulse.
- R5: After each hit, the target advances by the reload period. The nanosecond part wraps at 1,000,000,000 and carries one into the seconds.
- R6: A pin selector value of 1 carries channel A and a value of 2 carries channel B. Values 0 and 3 to 7 hold the pin low. A pin never follows the channel it is not routed to.
- R7: A pin drives (output-enable high) only when its bit is set in all three of these registers: enable at 0x05, direction at 0x06 and buffer at 0x07. A released pin outputs 0. The output-enable changes only after a register write.
- R8: Channel c uses the eight addresses starting at 0x08+8*c. Offsets 0 to 3 hold the target and offsets 4 to 7 hold the reload, each written as seconds-high, seconds-low, nanoseconds-high (14 valid bits) and nanoseconds-low. A new target or reload is committed only by the nanoseconds-low write, so a partly written target is never compared.
- R9: The selector for pin n (n=0 to 4) is at bits 3n+2:3n of address 0x01. The selector for pin n (n=5 to 9) is at bits 3(n-5)+2:3(n-5) of address 0x02.
- R10: A hit occurs when the time equals the target or is later than it. A time that jumps past the target still fires the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeSec | input | 32 | Current time, seconds |
| timeNs | input | 30 | Current time, nanoseconds (below 1,000,000,000) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 16 | Register write data |
| pinOut | output | NUM_PINS | Pin output levels |
| pinOe | output | NUM_PINS | Pin output enables |

## Verification
The hardest conditions to reach from the ports are the nanosecond wrap of the reload adder and a hit arriving while a pulse is still running. The bench reaches the wrap by placing a target 100 ns below a second boundary with a reload of 2 s plus 200 ns. It then probes one nanosecond before and exactly at each expected next target. The bench reaches the overlapping hit by jumping the time a whole second past a target that has a 100 ns reload, which makes the channel catch up on every cycle. The bench also sweeps all ten pins through four selector values, all eight gating combinations, and both polarities with each width code that fits a short run.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int NUM_CH = 2;
  localparam int SEC_W = 32;
  localparam int NS_W = 30;
  localparam int WORD_W = 16;
  localparam int NS_HI_W = NS_W - WORD_W;
  localparam int ADDR_W = 5;
  localparam int SEL_W = 3;
  localparam int PINS_PER_SEL = 5;
  localparam int CODE_W = 4;
  localparam int CH_STRIDE = 8;
  localparam int NUM_SLOT = 2 * NUM_CH;

  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  localparam logic [ADDR_W-1:0] ADR_CFG = 5'd0;
  localparam logic [ADDR_W-1:0] ADR_SEL0 = 5'd1;
  localparam logic [ADDR_W-1:0] ADR_EN = 5'd5;
  localparam logic [ADDR_W-1:0] ADR_DIR = 5'd6;
  localparam logic [ADDR_W-1:0] ADR_BUF = 5'd7;
  localparam logic [ADDR_W-1:0] ADR_CH0 = 5'd8;

  // Commit strobes from the register control to the channel datapath
  typedef struct packed {
    logic [NUM_CH-1:0] tgtLoad;
    logic [NUM_CH-1:0] rldLoad;
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
  } loadStrobe_t;

  function automatic int unsigned codeToNs(input logic [CODE_W-1:0] code);
    case (code)
      4'd0:  return 100;
      4'd1:  return 500;
      4'd2:  return 1000;
      4'd3:  return 5000;
      4'd4:  return 10000;
      4'd5:  return 50000;
      4'd6:  return 100000;
      4'd7:  return 500000;
      4'd8:  return 1000000;
      4'd9:  return 5000000;
      4'd10: return 10000000;
      4'd11: return 50000000;
      4'd12: return 100000000;
      4'd13: return 200000000;
      default: return 100;
    endcase
  endfunction

  function automatic int unsigned codeToCycles(input logic [CODE_W-1:0] code,
                                               input int unsigned nsPerCycle);
    int unsigned cyc;
    cyc = (codeToNs(code) + nsPerCycle - 1) / nsPerCycle;
    return (cyc == 0) ? 1 : cyc;
  endfunction
endpackage

// File: rtl/tpg_chan.sv
module tpg_chan
  import ptg_pkg::*;
#(
  parameter int NS_PER_CYCLE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEC_W-1:0]  timeSec,
  input  logic [NS_W-1:0]   timeNs,
  input  logic              tgtLoad,
  input  logic              rldLoad,
  input  logic [SEC_W-1:0]  loadSec,
  input  logic [NS_W-1:0]   loadNs,
  input  logic [CODE_W-1:0] widthCode,
  output logic              active
);
  localparam int unsigned MAX_CYC = codeToCycles(4'd13, NS_PER_CYCLE);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic armed;
  logic [SEC_W-1:0] tgtSec, rldSec, nextSec;
  logic [NS_W-1:0] tgtNs, rldNs, nextNs;
  logic [NS_W:0] nsSum;
  logic nsWrap, reached, hit;
  logic [CNT_W-1:0] widthCyc, cnt;

  always_comb begin
    reached = armed && ((timeSec > tgtSec) || ((timeSec == tgtSec) && (timeNs >= tgtNs)));
    hit = reached && !tgtLoad;
    nsSum = {1'b0, tgtNs} + {1'b0, rldNs};
    nsWrap = nsSum >= {1'b0, NS_PER_SEC};
    nextNs = nsWrap ? (nsSum[NS_W-1:0] - NS_PER_SEC) : nsSum[NS_W-1:0];
    nextSec = tgtSec + rldSec + {{(SEC_W-1){1'b0}}, nsWrap};
    widthCyc = CNT_W'(codeToCycles(widthCode, NS_PER_CYCLE));
  end

  // Target and reload registers; a hit advances the target by one period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      tgtSec <= '0;
      tgtNs  <= '0;
      rldSec <= '0;
      rldNs  <= '0;
    end else begin
      if (tgtLoad) begin
        armed  <= 1'b1;
        tgtSec <= loadSec;
        tgtNs  <= loadNs;
      end else if (hit) begin
        tgtSec <= nextSec;
        tgtNs  <= nextNs;
      end
      if (rldLoad) begin
        rldSec <= loadSec;
        rldNs  <= loadNs;
      end
    end
  end

  // Pulse timer; a hit during a running pulse does not restart it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else cnt <= cnt - CNT_W'(1);
    end else if (hit) begin
      active <= 1'b1;
      cnt    <= widthCyc - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tpg_regs.sv
module tpg_regs
  import ptg_pkg::*;
#(
  parameter int NUM_PINS = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [WORD_W-1:0]          wrData,
  output loadStrobe_t                strobe,
  output logic [NUM_CH-1:0]          pol,
  output logic [NUM_CH*CODE_W-1:0]   widthCode,
  output logic [NUM_PINS*SEL_W-1:0]  pinSel,
  output logic [NUM_PINS-1:0]        pinEn,
  output logic [NUM_PINS-1:0]        pinDir,
  output logic [NUM_PINS-1:0]        pinBuf
);
  logic [WORD_W-1:0] stSecHi [NUM_SLOT];
  logic [WORD_W-1:0] stSecLo [NUM_SLOT];
  logic [NS_HI_W-1:0] stNsHi [NUM_SLOT];
  logic inCh;
  int slotI, wordI, slotSel;

  always_comb begin
    inCh = (int'(wrAddr) >= int'(ADR_CH0)) &&
           (int'(wrAddr) < int'(ADR_CH0) + NUM_CH * CH_STRIDE);
    slotI = (int'(wrAddr) - int'(ADR_CH0)) / 4;
    wordI = int'(wrAddr) % 4;
    slotSel = inCh ? slotI : 0;
  end

  // Staged words of targets and reloads, kept until the final word arrives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOT; s++) begin
        stSecHi[s] <= '0;
        stSecLo[s] <= '0;
        stNsHi[s]  <= '0;
      end
    end else if (wrEn && inCh) begin
      case (wordI)
        0: stSecHi[slotSel] <= wrData;
        1: stSecLo[slotSel] <= wrData;
        2: stNsHi[slotSel]  <= wrData[NS_HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    strobe.sec = {stSecHi[slotSel], stSecLo[slotSel]};
    strobe.ns = {stNsHi[slotSel], wrData};
    if (wrEn && inCh && (wordI == 3)) begin
      if (slotSel % 2 == 0) strobe.tgtLoad[slotSel / 2] = 1'b1;
      else strobe.rldLoad[slotSel / 2] = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pol[c] <= 1'b0;
        widthCode[CODE_W*c +: CODE_W] <= '0;
      end else if (wrEn && wrAddr == ADR_CFG) begin
        pol[c] <= wrData[1 + 2*c];
        widthCode[CODE_W*c +: CODE_W] <= wrData[4 + 4*c +: CODE_W];
      end
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam logic [ADDR_W-1:0] SEL_ADR = ADDR_W'(int'(ADR_SEL0) + n / PINS_PER_SEL);
    localparam int SEL_LSB = SEL_W * (n % PINS_PER_SEL);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinSel[SEL_W*n +: SEL_W] <= '0;
        pinEn[n]  <= 1'b0;
        pinDir[n] <= 1'b0;
        pinBuf[n] <= 1'b0;
      end else if (wrEn) begin
        if (wrAddr == SEL_ADR) pinSel[SEL_W*n +: SEL_W] <= wrData[SEL_LSB +: SEL_W];
        if (wrAddr == ADR_EN)  pinEn[n]  <= wrData[n];
        if (wrAddr == ADR_DIR) pinDir[n] <= wrData[n];
        if (wrAddr == ADR_BUF) pinBuf[n] <= wrData[n];
      end
    end
  end
endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import ptg_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter int NS_PER_CYCLE = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SEC_W-1:0]          timeSec,
  input  logic [NS_W-1:0]           timeNs,
  input  loadStrobe_t               strobe,
  input  logic [NUM_CH-1:0]         pol,
  input  logic [NUM_CH*CODE_W-1:0]  widthCode,
  input  logic [NUM_PINS*SEL_W-1:0] pinSel,
  input  logic [NUM_PINS-1:0]       pinEn,
  input  logic [NUM_PINS-1:0]       pinDir,
  input  logic [NUM_PINS-1:0]       pinBuf,
  output logic [NUM_PINS-1:0]       pinOut,
  output logic [NUM_PINS-1:0]       pinOe,
  output logic [NUM_CH-1:0]         chanActive
);
  logic [NUM_CH-1:0] lvl;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tpg_chan #(.NS_PER_CYCLE(NS_PER_CYCLE)) u_chan (
      .clk       (clk),
      .rstN      (rstN),
      .timeSec   (timeSec),
      .timeNs    (timeNs),
      .tgtLoad   (strobe.tgtLoad[c]),
      .rldLoad   (strobe.rldLoad[c]),
      .loadSec   (strobe.sec),
      .loadNs    (strobe.ns),
      .widthCode (widthCode[CODE_W*c +: CODE_W]),
      .active    (chanActive[c])
    );
    assign lvl[c] = pol[c] ? chanActive[c] : ~chanActive[c];
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic routed;
    always_comb begin
      routed = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
        if (pinSel[SEL_W*n +: SEL_W] == SEL_W'(c + 1)) routed = lvl[c];
    end
    assign pinOe[n]  = pinEn[n] & pinDir[n] & pinBuf[n];
    assign pinOut[n] = pinOe[n] & routed;
  end
endmodule

// File: rtl/target_pulse_gen.sv
module target_pulse_gen
  import ptg_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter int NS_PER_CYCLE = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         timeSec,
  input  logic [29:0]         timeNs,
  input  logic                wrEn,
  input  logic [4:0]          wrAddr,
  input  logic [15:0]         wrData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  loadStrobe_t strobe;
  logic [NUM_CH-1:0] pol;
  logic [NUM_CH*CODE_W-1:0] widthCode;
  logic [NUM_PINS*SEL_W-1:0] pinSel;
  logic [NUM_PINS-1:0] pinEn, pinDir, pinBuf;
  logic [NUM_CH-1:0] chanActive;

  tpg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .pol       (pol),
    .widthCode (widthCode),
    .pinSel    (pinSel),
    .pinEn     (pinEn),
    .pinDir    (pinDir),
    .pinBuf    (pinBuf)
  );

  tpg_datapath #(.NUM_PINS(NUM_PINS), .NS_PER_CYCLE(NS_PER_CYCLE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .timeSec    (timeSec),
    .timeNs     (timeNs),
    .strobe     (strobe),
    .pol        (pol),
    .widthCode  (widthCode),
    .pinSel     (pinSel),
    .pinEn      (pinEn),
    .pinDir     (pinDir),
    .pinBuf     (pinBuf),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .chanActive (chanActive)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import ptg_pkg::*;
#(
  parameter int NUM_PINS = 10,
  parameter int NS_PER_CYCLE = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [NUM_PINS-1:0]      pinOut,
  input logic [NUM_PINS-1:0]      pinOe,
  input logic [NUM_CH-1:0]        chanActive,
  input logic [NUM_CH*CODE_W-1:0] widthCode
);
  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && pinOut == '0));

  // R7
  released_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0);

  // R7
  oe_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(pinOe));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    int unsigned runLen;
    logic [CODE_W-1:0] codeHeld;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runLen   <= 0;
        codeHeld <= '0;
      end else if (chanActive[c]) begin
        runLen <= runLen + 1;
      end else begin
        runLen   <= 0;
        codeHeld <= widthCode[CODE_W*c +: CODE_W];
      end
    end
    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(chanActive[c]) |-> runLen == codeToCycles(codeHeld, NS_PER_CYCLE));
  end
endmodule

bind target_pulse_gen tpg_checker #(.NUM_PINS(NUM_PINS), .NS_PER_CYCLE(NS_PER_CYCLE)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .pinOut     (pinOut),
  .pinOe      (pinOe),
  .chanActive (chanActive),
  .widthCode  (widthCode)
);

// File: tb/target_pulse_gen_tb.sv
module target_pulse_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPC = 100;
  localparam int NP = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [31:0] timeSec;
  logic [29:0] timeNs;
  logic wrEn;
  logic [4:0] wrAddr;
  logic [15:0] wrData;
  logic [NP-1:0] pinOut, pinOe;

  int checks = 0;
  int errors = 0;
  int unsigned base = 10;
  bit done = 0;

  target_pulse_gen #(.NUM_PINS(NP), .NS_PER_CYCLE(NPC)) u_dut (
    .clk(clk), .rstN(rstN), .timeSec(timeSec), .timeNs(timeNs),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expCyc(input int code);
    int c, ns, cyc;
    c = (code > 13) ? 0 : code;
    if (c == 13) ns = 200000000;
    else ns = 100 * ((c % 2) ? 5 : 1) * (10 ** (c / 2));
    cyc = (ns + NPC - 1) / NPC;
    return (cyc < 1) ? 1 : cyc;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input int unsigned s, input int unsigned n);
    @(negedge clk);
    timeSec = s; timeNs = 30'(n);
  endtask

  task automatic progTime(input int ch, input int kind, input int unsigned s, input int unsigned n);
    int a;
    a = 8 + 8*ch + 4*kind;
    wr(a, int'(s >> 16));
    wr(a + 1, int'(s & 32'hFFFF));
    wr(a + 2, int'(n >> 16));
    wr(a + 3, int'(n & 32'hFFFF));
  endtask

  task automatic armChan(input int ch);
    progTime(ch, 1, 60000, 0);
    progTime(ch, 0, base + 1, 0);
  endtask

  task automatic trig();
    setTime(base + 1, 0);
    base += 200;
  endtask

  task automatic measure(input int pin, input logic lvl, input int limit,
                         output int len, output int stray);
    len = 0; stray = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((pinOut & ~(10'b1 << pin)) != '0) stray++;
      if (pinOut[pin] == lvl) len++;
      else if (len > 0) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, stray, cfg, pin, code, w0, w1, en;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; timeSec = '0; timeNs = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(pinOe == '0, "R1 oe in reset", pinOe, 0);
    chk(pinOut == '0, "R1 out in reset", pinOut, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(pinOe == '0 && pinOut == '0, "R1 after reset", {pinOe, pinOut}, 0);

    // enable all pins; pin0 <- A, pin5 <- B
    wr(5, 'h3FF); wr(6, 'h3FF); wr(7, 'h3FF);
    wr(1, 'h0001); wr(2, 'h0002);
    chk(pinOe == 10'h3FF, "R7 all drive", pinOe, 'h3FF);

    // R3 / R4 sweep over channel, polarity and width code
    for (int ch = 0; ch < 2; ch++)
      for (int p = 0; p < 2; p++)
        for (int idx = 0; idx < 9; idx++) begin
          code = (idx == 8) ? 14 : idx;
          cfg = (p << (1 + 2*ch)) | (code << (4 + 4*ch));
          wr(0, cfg);
          armChan(ch);
          pin = ch ? 5 : 0;
          chk(pinOut[pin] == !p, "R4 idle level", pinOut[pin], !p);
          trig();
          measure(pin, p[0], expCyc(code) + 20, len, stray);
          chk(len == expCyc(code), "R3 pulse width", len, expCyc(code));
        end

    // R2 / R10 on channel A, code 1, active high
    wr(0, 'h0012);
    progTime(0, 1, 60000, 0);
    progTime(0, 0, base + 1, 500);
    setTime(base + 1, 499);
    measure(0, 1'b1, 30, len, stray);
    chk(len == 0, "R2 one ns early", len, 0);
    setTime(base + 1, 500);
    measure(0, 1'b1, 40, len, stray);
    chk(len == expCyc(1), "R10 equal time", len, expCyc(1));
    base += 200;
    progTime(0, 0, base + 1, 0);
    setTime(base + 50, 7);
    measure(0, 1'b1, 40, len, stray);
    chk(len == expCyc(1), "R10 time jumped past", len, expCyc(1));
    measure(0, 1'b1, 30, len, stray);
    chk(len == 0, "R5 no repeat before reload", len, 0);
    base += 200;

    // R8 partial target write on channel B
    wr(0, 'h0108);
    progTime(1, 1, 60000, 0);
    progTime(1, 0, base + 100, 0);
    setTime(base + 5, 0);
    wr(16, int'((base + 2) >> 16));
    wr(17, int'((base + 2) & 32'hFFFF));
    wr(18, 0);
    measure(5, 1'b1, 30, len, stray);
    chk(len == 0, "R8 partial target ignored", len, 0);
    wr(19, 0);
    measure(5, 1'b1, 40, len, stray);
    chk(len == expCyc(1), "R8 commit on final word", len, expCyc(1));
    base += 200;

    // R9 / R6 routing sweep, both channels active high code 1
    wr(0, 'h011A);
    for (int pn = 0; pn < NP; pn++)
      for (int route = 0; route < 4; route++) begin
        w0 = (pn < 5) ? (route << (3*pn)) : 0;
        w1 = (pn >= 5) ? (route << (3*(pn-5))) : 0;
        wr(1, w0); wr(2, w1);
        armChan((route == 2) ? 1 : 0);
        trig();
        measure(pn, 1'b1, 40, len, stray);
        if (route == 1 || route == 2)
          chk(len == expCyc(1), "R9 selector field", len, expCyc(1));
        else
          chk(len == 0, "R6 unrouted pin low", len, 0);
        chk(stray == 0, "R9 other pins quiet", stray, 0);
      end
    // R6 cross-channel isolation on pin 2
    wr(1, 2 << 6); wr(2, 0);
    armChan(0); trig();
    measure(2, 1'b1, 40, len, stray);
    chk(len == 0, "R6 B-routed pin ignores A", len, 0);
    wr(1, 1 << 6);
    armChan(1); trig();
    measure(2, 1'b1, 40, len, stray);
    chk(len == 0, "R6 A-routed pin ignores B", len, 0);

    // R7 gating sweep on pin 3 routed to A
    wr(1, 1 << 9); wr(2, 0);
    for (int combo = 0; combo < 8; combo++) begin
      en = 'h3F7;
      wr(5, combo[0] ? 'h3FF : en);
      wr(6, combo[1] ? 'h3FF : en);
      wr(7, combo[2] ? 'h3FF : en);
      chk(pinOe[3] == (combo == 7), "R7 oe gating", pinOe[3], combo == 7);
      armChan(0); trig();
      measure(3, 1'b1, 40, len, stray);
      chk(len == ((combo == 7) ? expCyc(1) : 0), "R7 released pin quiet", len,
          (combo == 7) ? expCyc(1) : 0);
    end

    // R5 nanosecond wrap with carry, pin0 routed to A
    wr(1, 1); wr(2, 0);
    progTime(0, 1, 2, 200);
    progTime(0, 0, base + 1, 999999900);
    setTime(base + 1, 999999900);
    measure(0, 1'b1, 40, len, stray);
    chk(len == expCyc(1), "R5 first hit", len, expCyc(1));
    setTime(base + 4, 99);
    measure(0, 1'b1, 30, len, stray);
    chk(len == 0, "R5 wrapped target not early", len, 0);
    setTime(base + 4, 100);
    measure(0, 1'b1, 40, len, stray);
    chk(len == expCyc(1), "R5 wrapped target hit", len, expCyc(1));
    setTime(base + 6, 299);
    measure(0, 1'b1, 30, len, stray);
    chk(len == 0, "R5 second advance not early", len, 0);
    setTime(base + 6, 300);
    measure(0, 1'b1, 40, len, stray);
    chk(len == expCyc(1), "R5 second advance hit", len, expCyc(1));
    base += 200;

    // R3 hits during a running pulse do not extend it (catch-up)
    progTime(0, 1, 0, 100);
    progTime(0, 0, base + 1, 0);
    setTime(base + 2, 0);
    measure(0, 1'b1, 40, len, stray);
    chk(len == expCyc(1), "R3 catch-up pulse not extended", len, expCyc(1));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule